// File: doc/BRIEF.md
# Balanced Ternary Program Counter

This block is a synchronous program counter that keeps its value in balanced ternary rather than binary. The count is a word of trits, and every trit sits on a two-bit code. Code `10` means +1, `11` means 0 and `01` means -1. Code `00` is not a legal trit. With the default of four trits the count covers -40 to +40.

A two-bit direction input chooses whether the count steps up by one, steps down by one or stays put on each clock. A load strobe replaces the count with a parallel trit word on the next edge. The strobe serves both for initialisation and for jumps, and it wins over any stepping.

The increment and the decrement are done digit by digit in ternary. A carry or borrow ripples from the least significant trit upward. All pins are plain control and data levels, with no handshake. The count is presented on every cycle.

Top module: `bt_pc`

## Requirements
- R1: While `rst_n` is low, every trit of `count` is forced to the 0 code `11`, so `count` reads `8'hFF` (value 0).
- R2: Trit i of `count` occupies bits [2i+1:2i], so the most significant trit is in bits [7:6]. Every trit of `count` always holds one of the legal codes: `10` for +1, `11` for 0 or `01` for -1.
- R3: When `load` is high at a clock edge, `count` takes the value of `load_val` after that edge, whatever `dir` is. `load_val` uses the same trit layout and codes as `count`.
- R4: A `00` trit in `load_val` is captured as the 0 code `11`. The other trits are captured as given.
- R5: With `load` low and `dir` = `01`, each edge raises the count by exactly one. A +1 trit that receives a carry becomes -1 and passes the carry on. A 0 trit becomes +1 and a -1 trit becomes 0, and neither passes the carry on.
- R6: With `load` low and `dir` = `10`, each edge lowers the count by exactly one. A -1 trit that receives a borrow becomes +1 and passes the borrow on. A 0 trit becomes -1 and a +1 trit becomes 0, and neither passes the borrow on.
- R7: With `load` low and `dir` = `00` or `11`, `count` keeps its value across the edge.
- R8: Counting up from +40 (`8'hAA`) gives -40 (`8'h55`).
- R9: Counting down from -40 (`8'h55`) gives +40 (`8'hAA`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Parallel load strobe, has priority over stepping |
| load_val | input | 8 | Trit word to load, two bits per trit, most significant trit at the top |
| dir | input | 2 | Step direction: 00 hold, 01 up, 10 down, 11 hold |
| count | output | 8 | Current count as four trit codes, most significant trit at the top |

## Verification
All 256 bit patterns are loaded. The 81 legal words check plain capture. The patterns that contain a `00` pair show whether illegal trits are cleaned to zero, in each trit position.

For every value from -40 to +40, the counter is loaded and then stepped once up, once down, and held with both hold codes. Each case is checked against a value computed arithmetically. This separates correct carry and borrow chains of every length from wrong ones, and it exercises both wrap points.

A load is also issued while a step direction is active, to show that load has priority. Long free-running sweeps up and down across the full range then confirm that successive steps chain correctly.

// File: rtl/bt_pc_pkg.sv
package bt_pc_pkg;
  localparam logic [1:0] TC_POS  = 2'b10;
  localparam logic [1:0] TC_ZERO = 2'b11;
  localparam logic [1:0] TC_NEG  = 2'b01;
  localparam logic [1:0] TC_BAD  = 2'b00;

  typedef enum logic [1:0] {
    DIR_HOLD_A = 2'b00,
    DIR_UP     = 2'b01,
    DIR_DOWN   = 2'b10,
    DIR_HOLD_B = 2'b11
  } dir_e;

  function automatic logic [1:0] tc_clean(input logic [1:0] c);
    return (c == TC_BAD) ? TC_ZERO : c;
  endfunction
endpackage

// File: rtl/bt_dir_decode.sv
module bt_dir_decode
  import bt_pc_pkg::*;
(
  input  logic [1:0] dir_i,
  output logic       step_en_o,
  output logic       step_up_o
);
  always_comb begin
    step_en_o = 1'b0;
    step_up_o = 1'b0;
    case (dir_e'(dir_i))
      DIR_UP:   begin step_en_o = 1'b1; step_up_o = 1'b1; end
      DIR_DOWN: begin step_en_o = 1'b1; step_up_o = 1'b0; end
      default:  begin step_en_o = 1'b0; step_up_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/bt_load_clean.sv
module bt_load_clean
  import bt_pc_pkg::*;
#(
  parameter int NUM_TRITS = 4,
  localparam int W = 2 * NUM_TRITS
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] clean_o
);
  for (genvar i = 0; i < NUM_TRITS; i++) begin : g_trit
    assign clean_o[2*i +: 2] = tc_clean(raw_i[2*i +: 2]);
  end
endmodule

// File: rtl/bt_trit_step.sv
module bt_trit_step
  import bt_pc_pkg::*;
(
  input  logic [1:0] code_i,
  input  logic       ripple_i,
  input  logic       up_i,
  output logic [1:0] code_o,
  output logic       ripple_o
);
  logic [1:0] cur;
  assign cur = tc_clean(code_i);

  always_comb begin
    code_o   = cur;
    ripple_o = 1'b0;
    if (ripple_i) begin
      if (up_i) begin
        case (cur)
          TC_POS:  begin code_o = TC_NEG;  ripple_o = 1'b1; end
          TC_ZERO: code_o = TC_POS;
          default: code_o = TC_ZERO;
        endcase
      end else begin
        case (cur)
          TC_NEG:  begin code_o = TC_POS;  ripple_o = 1'b1; end
          TC_ZERO: code_o = TC_NEG;
          default: code_o = TC_ZERO;
        endcase
      end
    end
  end
endmodule

// File: rtl/bt_pc.sv
module bt_pc
  import bt_pc_pkg::*;
#(
  parameter int NUM_TRITS = 4,
  localparam int W = 2 * NUM_TRITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [1:0]   dir,
  output logic [W-1:0] count
);
  logic [W-1:0]         cnt_q;
  logic [W-1:0]         stepped;
  logic [W-1:0]         loaded;
  logic [NUM_TRITS-1:0] ripple;
  logic                 step_en;
  logic                 step_up;

  bt_dir_decode u_dir (
    .dir_i     (dir),
    .step_en_o (step_en),
    .step_up_o (step_up)
  );

  bt_load_clean #(.NUM_TRITS(NUM_TRITS)) u_clean (
    .raw_i   (load_val),
    .clean_o (loaded)
  );

  for (genvar i = 0; i < NUM_TRITS; i++) begin : g_chain
    logic rin;
    if (i == 0) begin : g_lsb
      assign rin = step_en;
    end else begin : g_up
      assign rin = ripple[i-1];
    end
    bt_trit_step u_step (
      .code_i   (cnt_q[2*i +: 2]),
      .ripple_i (rin),
      .up_i     (step_up),
      .code_o   (stepped[2*i +: 2]),
      .ripple_o (ripple[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= {NUM_TRITS{TC_ZERO}};
    else if (load) cnt_q <= loaded;
    else           cnt_q <= stepped;
  end

  assign count = cnt_q;
endmodule

// File: rtl/bt_pc_checker.sv
module bt_pc_checker #(
  parameter int NUM_TRITS = 4,
  localparam int W = 2 * NUM_TRITS
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic [W-1:0] load_val,
  input logic [1:0]   dir,
  input logic [W-1:0] count,
  input logic         top_ripple
);
  function automatic int tval(input logic [W-1:0] c);
    int s = 0;
    int p = 1;
    for (int i = 0; i < NUM_TRITS; i++) begin
      if (c[2*i +: 2] == 2'b10) s += p;
      else if (c[2*i +: 2] == 2'b01) s -= p;
      p *= 3;
    end
    return s;
  endfunction

  function automatic logic any_bad(input logic [W-1:0] c);
    logic b = 1'b0;
    for (int i = 0; i < NUM_TRITS; i++) b |= (c[2*i +: 2] == 2'b00);
    return b;
  endfunction

  function automatic int maxv();
    int p = 1;
    for (int i = 0; i < NUM_TRITS; i++) p *= 3;
    return (p - 1) / 2;
  endfunction

  a_r1_reset_zero: assert property (@(posedge clk) $rose(rst_n) |-> count == {NUM_TRITS{2'b11}});

  a_r2_legal_codes: assert property (@(posedge clk) disable iff (!rst_n) !any_bad(count));

  a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load && !any_bad(load_val) |=> count == $past(load_val));

  a_r4_bad_as_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load && any_bad(load_val) |=> tval(count) == tval($past(load_val)));

  a_r5_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    !load && dir == 2'b01 && tval(count) != maxv() |=> tval(count) == tval($past(count)) + 1);

  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    !load && dir == 2'b10 && tval(count) != -maxv() |=> tval(count) == tval($past(count)) - 1);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load && (dir == 2'b00 || dir == 2'b11) |=> $stable(count));

  a_r8_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    !load && dir == 2'b01 && top_ripple |=> tval(count) == -maxv());

  a_r9_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    !load && dir == 2'b10 && tval(count) == -maxv() |=> tval(count) == maxv());
endmodule

bind bt_pc bt_pc_checker #(.NUM_TRITS(NUM_TRITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .load_val   (load_val),
  .dir        (dir),
  .count      (count),
  .top_ripple (ripple[NUM_TRITS-1])
);

// File: tb/bt_pc_tb_top.sv
module bt_pc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] load_val = 8'hFF;
  logic [1:0] dir = 2'b00;
  logic [7:0] count;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bt_pc dut_i (
    .clk(clk), .rst_n(rst_n), .load(load),
    .load_val(load_val), .dir(dir), .count(count)
  );

  function automatic logic [7:0] enc(input int v);
    logic [7:0] c;
    int x = v;
    for (int i = 0; i < 4; i++) begin
      int r = ((x % 3) + 3) % 3;
      int t = (r == 2) ? -1 : r;
      c[2*i +: 2] = (t == 1) ? 2'b10 : (t == 0) ? 2'b11 : 2'b01;
      x = (x - t) / 3;
    end
    return c;
  endfunction

  function automatic int dec(input logic [7:0] c);
    int s = 0;
    int p = 1;
    for (int i = 0; i < 4; i++) begin
      if (c[2*i +: 2] == 2'b10) s += p;
      else if (c[2*i +: 2] == 2'b01) s -= p;
      p *= 3;
    end
    return s;
  endfunction

  function automatic logic has_bad(input logic [7:0] c);
    logic b = 1'b0;
    for (int i = 0; i < 4; i++) b |= (c[2*i +: 2] == 2'b00);
    return b;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: count=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic [7:0] v, input logic [1:0] d);
    @(negedge clk);
    load = ld; load_val = v; dir = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1", count, 8'hFF);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk("R1", count, 8'hFF);

    // R3 / R4: every load pattern
    for (int p = 0; p < 256; p++) begin
      step(1'b1, p[7:0], 2'b00);
      if (has_bad(p[7:0])) chk("R4", count, enc(dec(p[7:0])));
      else chk("R3", count, p[7:0]);
    end

    for (int v = -40; v <= 40; v++) begin
      step(1'b1, enc(v), 2'b00);
      step(1'b0, 8'h00, 2'b01);
      chk(v == 40 ? "R8" : "R5", count, enc(v == 40 ? -40 : v + 1));
      step(1'b1, enc(v), 2'b00);
      step(1'b0, 8'h00, 2'b10);
      chk(v == -40 ? "R9" : "R6", count, enc(v == -40 ? 40 : v - 1));
      step(1'b1, enc(v), 2'b00);
      step(1'b0, 8'h00, 2'b00);
      chk("R7", count, enc(v));
      step(1'b0, 8'h00, 2'b11);
      chk("R7", count, enc(v));
      step(1'b1, enc(-v), 2'b01);
      chk("R3", count, enc(-v));
      step(1'b1, enc(v), 2'b10);
      chk("R3", count, enc(v));
      chk("R2", {6'd0, count[7:6]}, {6'd0, enc(v)[7:6]});
    end

    // Free-running sweeps
    step(1'b1, enc(-40), 2'b00);
    for (int k = 1; k <= 82; k++) begin
      step(1'b0, 8'h00, 2'b01);
      chk("R5", count, enc(((-40 + k + 40) % 81) - 40));
    end
    for (int k = 1; k <= 82; k++) begin
      step(1'b0, 8'h00, 2'b10);
      chk("R6", count, enc((((-39 - k + 40) % 81) + 81) % 81 - 40));
    end

    rst_n = 1'b0;
    #1 chk("R1", count, 8'hFF);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: count=%h expected=finished", count);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule